// File: doc/BRIEF.md
# Quad-Rate Burst-of-Four Synchronous SRAM Model

This block is a synthesizable behavioural model of a synchronous SRAM with a separate write data bus and read data bus. Both buses move data on the rising edges of two single-ended input clocks: a primary clock and a second clock driven as its complement. Every access moves a burst of four beats, two per clock cycle. A read and a write can each be started in the same two-cycle command slot, so the two buses carry traffic at the same time.

A write gathers four incoming beats, each with its own byte mask, into one internal word four times the bus width. It then commits that word to the on-chip array in a single masked store. A read fetches one wide word and replays it as four double-rate beats. The first beat appears two and a half cycles after the command, and a valid strobe marks the beats. The write path and the read path are kept coherent: a read always sees every write from an earlier slot, even one whose store lands on the same edge as the fetch.

Top module: `qdr_b4_sram`

## Requirements
- R1: While `rst_n` is low and after it is released, `rvalid` is low and `rdata` is zero. Reset clears every word of the array to zero.
- R2: Commands are sampled on rising `clk_k` edges in the first cycle of a two-cycle slot. The first such edge after reset release opens a slot. A `rd_en` or `wr_en` seen in the second cycle of a slot is ignored.
- R3: An accepted write takes beat 0 from `wdata` at the accepting `clk_k` edge, beat 1 at the next `clk_kb` edge, beat 2 at the next `clk_k` edge and beat 3 at the `clk_kb` edge after that. Beat i fills bits [i*DW +: DW] of the stored word.
- R4: With each write beat, `wbe[b]` high stores bits [b*BW +: BW] of that beat (BW = DW/NB). With `wbe[b]` low, that byte keeps its previous content. A write with every enable low changes nothing.
- R5: After a read is accepted on a `clk_k` edge, beat 0 appears on `rdata` at the `clk_kb` edge 2.5 cycles later. Beats 1, 2 and 3 follow on the next `clk_k`, `clk_kb` and `clk_k` edges.
- R6: `rvalid` is high while exactly those four beats are on `rdata` and low at all other times. Reads in consecutive slots give an unbroken run of beats.
- R7: When a read and a write are accepted in the same slot, the read returns the contents from before that write, even when the addresses match.
- R8: A read accepted in any later slot returns the data of every earlier write, with the byte masks applied. This holds even when that write's store to the array falls on the edge that fetches the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_k | input | 1 | Primary clock; commands and beats 0/2 are sampled on its rising edge |
| clk_kb | input | 1 | Complement clock; beats 1/3 are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_en | input | 1 | Read command request |
| rd_addr | input | AW | Read word address |
| wr_en | input | 1 | Write command request |
| wr_addr | input | AW | Write word address |
| wdata | input | DW | Write data beat |
| wbe | input | NB | Per-beat byte enables, active high |
| rdata | output | DW | Read data beat, zero when idle |
| rvalid | output | 1 | High while a read beat is presented |

## Verification
The bench reads an address in the slot after it was written. In that case the masked store and the fetch share an edge, and a design without forwarding would return the stale word. A read in the same slot as a write to the same address must still return the old word; a design that orders the write first returns the new data. The bench sends partial and all-off byte masks, which expose a design that latches one mask per burst instead of one per beat. It also drives commands in the second cycle of a slot: a design that accepted them would put extra valid beats on the bus or corrupt a word read later. Every edge is checked for `rvalid`, so a read latency off by half a cycle shows up as misplaced beats.

// File: rtl/qdr_b4_pkg.sv
`timescale 1ns/1ps
package qdr_b4_pkg;
  // Beats per access; the array word is this many bus words wide.
  localparam int unsigned BURST = 4;

  // Progress of a write burst in the primary-clock domain.
  typedef enum logic [1:0] {
    GATHER_IDLE   = 2'd0,
    GATHER_UPPER  = 2'd1,
    GATHER_COMMIT = 2'd2
  } gather_e;
endpackage

// File: rtl/qdr_wr_gather.sv
`timescale 1ns/1ps
module qdr_wr_gather
  import qdr_b4_pkg::*;
#(
  parameter int unsigned DW = 18,
  parameter int unsigned NB = 2,
  parameter int unsigned AW = 8
) (
  input  logic                  clk_k,
  input  logic                  clk_kb,
  input  logic                  rst_n,
  input  logic                  wr_acc,
  input  logic [AW-1:0]         wr_addr,
  input  logic [DW-1:0]         wdata,
  input  logic [NB-1:0]         wbe,
  output logic                  commit,
  output logic [AW-1:0]         commit_addr,
  output logic [BURST*DW-1:0]   commit_word,
  output logic [BURST*NB-1:0]   commit_mask
);
  gather_e          phase_q;
  logic [DW-1:0]    beat0_q, beat2_q;
  logic [NB-1:0]    mask0_q, mask2_q;
  logic [AW-1:0]    addr_q;
  // Complement-clock side: a two-deep history of beats and masks.
  logic [DW-1:0]    kb_old_d, kb_new_d;
  logic [NB-1:0]    kb_old_m, kb_new_m;

  always_ff @(posedge clk_kb) begin
    if (!rst_n) begin
      kb_old_d <= '0;
      kb_new_d <= '0;
      kb_old_m <= '0;
      kb_new_m <= '0;
    end else begin
      kb_old_d <= kb_new_d;
      kb_new_d <= wdata;
      kb_old_m <= kb_new_m;
      kb_new_m <= wbe;
    end
  end

  always_ff @(posedge clk_k) begin
    if (!rst_n) begin
      phase_q <= GATHER_IDLE;
      beat0_q <= '0;
      beat2_q <= '0;
      mask0_q <= '0;
      mask2_q <= '0;
      addr_q  <= '0;
    end else if (phase_q == GATHER_UPPER) begin
      beat2_q <= wdata;
      mask2_q <= wbe;
      phase_q <= GATHER_COMMIT;
    end else if (wr_acc) begin
      beat0_q <= wdata;
      mask0_q <= wbe;
      addr_q  <= wr_addr;
      phase_q <= GATHER_UPPER;
    end else begin
      phase_q <= GATHER_IDLE;
    end
  end

  // At the commit edge the complement history holds beats 1 (old) and 3 (new).
  assign commit      = (phase_q == GATHER_COMMIT);
  assign commit_addr = addr_q;
  assign commit_word = {kb_new_d, beat2_q, kb_old_d, beat0_q};
  assign commit_mask = {kb_new_m, mask2_q, kb_old_m, mask0_q};

  // R3: an accepted write stores its assembled word exactly two edges later
  a_r3_commit_two_later: assert property (@(posedge clk_k) disable iff (!rst_n)
    wr_acc |-> ##2 commit);
endmodule

// File: rtl/qdr_store.sv
`timescale 1ns/1ps
module qdr_store
  import qdr_b4_pkg::*;
#(
  parameter int unsigned DW    = 18,
  parameter int unsigned NB    = 2,
  parameter int unsigned DEPTH = 256,
  parameter int unsigned AW    = 8
) (
  input  logic                  clk_k,
  input  logic                  rst_n,
  input  logic                  commit,
  input  logic [AW-1:0]         commit_addr,
  input  logic [BURST*DW-1:0]   commit_word,
  input  logic [BURST*NB-1:0]   commit_mask,
  input  logic                  rd_acc,
  input  logic [AW-1:0]         rd_addr,
  output logic [BURST*DW-1:0]   fetch_word
);
  localparam int unsigned WW = BURST * DW;
  localparam int unsigned MW = BURST * NB;
  localparam int unsigned BW = DW / NB;

  logic [WW-1:0] mem [DEPTH];
  logic          fwd_hit;
  logic [WW-1:0] stored_next;

  function automatic logic [WW-1:0] merge_bytes(input logic [WW-1:0] old_w,
                                                input logic [WW-1:0] new_w,
                                                input logic [MW-1:0] m);
    logic [WW-1:0] res;
    res = old_w;
    for (int k = 0; k < MW; k++) begin
      if (m[k]) res[k*BW +: BW] = new_w[k*BW +: BW];
    end
    return res;
  endfunction

  assign stored_next = merge_bytes(mem[commit_addr], commit_word, commit_mask);
  // A store and a fetch of the same word on one edge: hand the merged word over.
  assign fwd_hit     = commit && rd_acc && (commit_addr == rd_addr);

  always_ff @(posedge clk_k) begin
    if (!rst_n) begin
      for (int a = 0; a < DEPTH; a++) mem[a] <= '0;
      fetch_word <= '0;
    end else begin
      if (commit) mem[commit_addr] <= stored_next;
      if (rd_acc) fetch_word <= fwd_hit ? stored_next : mem[rd_addr];
    end
  end

  // R8: the fetched word always equals the array content once the edge settles
  a_r8_fetch_coherent: assert property (@(posedge clk_k) disable iff (!rst_n)
    rd_acc |=> (fetch_word == mem[$past(rd_addr)]));
endmodule

// File: rtl/qdr_rd_serial.sv
`timescale 1ns/1ps
module qdr_rd_serial
  import qdr_b4_pkg::*;
#(
  parameter int unsigned DW = 18
) (
  input  logic                  clk_k,
  input  logic                  clk_kb,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [BURST*DW-1:0]   word,
  output logic [DW-1:0]         rdata,
  output logic                  rvalid
);
  logic [BURST*DW-1:0] out_word;
  logic                out_v, out_upper;
  logic [DW-1:0]       q_k, q_kb;
  logic                v_k, v_kb;

  function automatic logic [DW-1:0] beat_of(input logic [BURST*DW-1:0] w, input int idx);
    return w[idx*DW +: DW];
  endfunction

  // Primary domain: owns the word being replayed and launches odd beats.
  always_ff @(posedge clk_k) begin
    if (!rst_n) begin
      out_word  <= '0;
      out_v     <= 1'b0;
      out_upper <= 1'b0;
      q_k       <= '0;
      v_k       <= 1'b0;
    end else begin
      q_k <= out_v ? beat_of(out_word, out_upper ? 3 : 1) : '0;
      v_k <= out_v;
      if (load) begin
        out_word  <= word;
        out_v     <= 1'b1;
        out_upper <= 1'b0;
      end else if (out_v && !out_upper) begin
        out_upper <= 1'b1;
      end else begin
        out_v     <= 1'b0;
        out_upper <= 1'b0;
      end
    end
  end

  // Complement domain: launches even beats half a cycle after the load edge.
  always_ff @(posedge clk_kb) begin
    if (!rst_n) begin
      q_kb <= '0;
      v_kb <= 1'b0;
    end else begin
      q_kb <= out_v ? beat_of(out_word, out_upper ? 2 : 0) : '0;
      v_kb <= out_v;
    end
  end

  // The latest launching edge owns the bus: high clock follows a primary edge.
  assign rdata  = clk_k ? q_k : q_kb;
  assign rvalid = clk_k ? v_k : v_kb;

  // R6: each burst holds the primary-edge strobe for two consecutive cycles
  a_r6_strobe_pair_k: assert property (@(posedge clk_k) disable iff (!rst_n)
    $rose(v_k) |=> v_k);
  // R6: and the complement-edge strobe likewise
  a_r6_strobe_pair_kb: assert property (@(posedge clk_kb) disable iff (!rst_n)
    $rose(v_kb) |=> v_kb);
endmodule

// File: rtl/qdr_b4_sram.sv
`timescale 1ns/1ps
module qdr_b4_sram
  import qdr_b4_pkg::*;
#(
  parameter  int unsigned DW    = 18,
  parameter  int unsigned NB    = 2,
  parameter  int unsigned DEPTH = 256,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic            clk_k,
  input  logic            clk_kb,
  input  logic            rst_n,
  input  logic            rd_en,
  input  logic [AW-1:0]   rd_addr,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wdata,
  input  logic [NB-1:0]   wbe,
  output logic [DW-1:0]   rdata,
  output logic            rvalid
);
  localparam int unsigned WW = BURST * DW;

  logic          slot_second;
  logic          rd_acc, wr_acc;
  logic          commit;
  logic [AW-1:0] commit_addr;
  logic [WW-1:0] commit_word;
  logic [BURST*NB-1:0] commit_mask;
  logic [WW-1:0] fetch_word;
  logic          fetch_v;
  logic [WW-1:0] stage_word;
  logic          stage_v;

  // Two-cycle command slot, opened by the first edge after reset release.
  always_ff @(posedge clk_k) begin
    if (!rst_n) slot_second <= 1'b0;
    else        slot_second <= ~slot_second;
  end

  assign rd_acc = rst_n && rd_en && !slot_second;
  assign wr_acc = rst_n && wr_en && !slot_second;

  qdr_wr_gather #(.DW(DW), .NB(NB), .AW(AW)) u_gather (
    .clk_k       (clk_k),
    .clk_kb      (clk_kb),
    .rst_n       (rst_n),
    .wr_acc      (wr_acc),
    .wr_addr     (wr_addr),
    .wdata       (wdata),
    .wbe         (wbe),
    .commit      (commit),
    .commit_addr (commit_addr),
    .commit_word (commit_word),
    .commit_mask (commit_mask)
  );

  qdr_store #(.DW(DW), .NB(NB), .DEPTH(DEPTH), .AW(AW)) u_store (
    .clk_k       (clk_k),
    .rst_n       (rst_n),
    .commit      (commit),
    .commit_addr (commit_addr),
    .commit_word (commit_word),
    .commit_mask (commit_mask),
    .rd_acc      (rd_acc),
    .rd_addr     (rd_addr),
    .fetch_word  (fetch_word)
  );

  // One stage between fetch and replay sets the 2.5-cycle first-beat latency.
  always_ff @(posedge clk_k) begin
    if (!rst_n) begin
      fetch_v    <= 1'b0;
      stage_v    <= 1'b0;
      stage_word <= '0;
    end else begin
      fetch_v    <= rd_acc;
      stage_v    <= fetch_v;
      stage_word <= fetch_word;
    end
  end

  qdr_rd_serial #(.DW(DW)) u_serial (
    .clk_k  (clk_k),
    .clk_kb (clk_kb),
    .rst_n  (rst_n),
    .load   (stage_v),
    .word   (stage_word),
    .rdata  (rdata),
    .rvalid (rvalid)
  );

  // R2: no read accepted on two consecutive edges
  a_r2_read_once_per_slot: assert property (@(posedge clk_k) disable iff (!rst_n)
    rd_acc |=> !rd_acc);
  // R2: no write accepted on two consecutive edges
  a_r2_write_once_per_slot: assert property (@(posedge clk_k) disable iff (!rst_n)
    wr_acc |=> !wr_acc);
  // R5: an accepted read reaches the replay stage two edges later
  a_r5_read_pipe_depth: assert property (@(posedge clk_k) disable iff (!rst_n)
    rd_acc |-> ##2 stage_v);
endmodule

// File: tb/test_qdr_b4_sram.sv
`timescale 1ns/1ps
module test_qdr_b4_sram;
  localparam int DW = 18;
  localparam int NB = 2;
  localparam int DEPTH = 256;
  localparam int AW = 8;
  localparam int BW = DW / NB;
  localparam int WW = 4 * DW;

  typedef struct packed {
    logic        rd;
    logic [7:0]  ra;
    logic        wr;
    logic [7:0]  wa;
    logic [17:0] seed;
    logic [7:0]  msk;   // bit i*NB+b enables byte b of beat i
    logic        stray; // also drive commands in the slot's second cycle
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h00, 1'b1, 8'h10, 18'h12345, 8'hFF, 1'b0},  // R3 full write
    '{1'b1, 8'h10, 1'b1, 8'h20, 18'h2A0F1, 8'hFF, 1'b0},  // R8 read after write
    '{1'b1, 8'h20, 1'b1, 8'h20, 18'h3C3C3, 8'h99, 1'b0},  // R7 same slot, R4 partial
    '{1'b1, 8'h20, 1'b0, 8'h00, 18'h00000, 8'h00, 1'b0},  // R4/R8 merged word
    '{1'b1, 8'h10, 1'b1, 8'h30, 18'h15555, 8'h00, 1'b0},  // R4 all enables off
    '{1'b1, 8'h30, 1'b0, 8'h00, 18'h2BEEF, 8'hFF, 1'b1},  // R2 stray commands
    '{1'b1, 8'h40, 1'b1, 8'h40, 18'h0F0F0, 8'hFF, 1'b1},  // R7 same slot, R2 stray
    '{1'b1, 8'h40, 1'b0, 8'h00, 18'h00000, 8'h00, 1'b0},  // R8
    '{1'b0, 8'h00, 1'b0, 8'h00, 18'h00000, 8'h00, 1'b0},
    '{1'b1, 8'hFF, 1'b1, 8'hFF, 18'h1FFFF, 8'hFF, 1'b0},  // top address
    '{1'b1, 8'hFF, 1'b0, 8'h00, 18'h00000, 8'h00, 1'b0},  // R6 back-to-back
    '{1'b0, 8'h00, 1'b1, 8'h10, 18'h33333, 8'hF0, 1'b0},  // R4 upper beats only
    '{1'b1, 8'h10, 1'b0, 8'h00, 18'h00000, 8'h00, 1'b0},
    '{1'b1, 8'h20, 1'b0, 8'h00, 18'h00000, 8'h00, 1'b0},  // R6 back-to-back
    '{1'b0, 8'h00, 1'b0, 8'h00, 18'h00000, 8'h00, 1'b0},
    '{1'b0, 8'h00, 1'b0, 8'h00, 18'h00000, 8'h00, 1'b0}
  };

  logic clk_k = 1'b0;
  logic clk_kb = 1'b1;
  logic rst_n = 1'b0;
  logic rd_en = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] rd_addr = '0, wr_addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [NB-1:0] wbe = '0;
  logic [DW-1:0] rdata;
  logic rvalid;

  int checks = 0;
  int fails = 0;
  int hc = 0;
  logic [DW-1:0]  exp_d [int];
  logic [WW-1:0]  ref_mem [DEPTH];

  always #2 clk_k = ~clk_k;    // 250 MHz
  always #2 clk_kb = ~clk_kb;

  qdr_b4_sram #(.DW(DW), .NB(NB), .DEPTH(DEPTH)) i_qdr_b4_sram (
    .clk_k(clk_k), .clk_kb(clk_kb), .rst_n(rst_n),
    .rd_en(rd_en), .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr),
    .wdata(wdata), .wbe(wbe), .rdata(rdata), .rvalid(rvalid)
  );

  function automatic logic [DW-1:0] mk_beat(input logic [17:0] s, input int i);
    return DW'(s + 18'(i * 40503));
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Every edge, half a cycle's middle: beat expected here (R5) or idle bus (R6).
  always @(posedge clk_k or posedge clk_kb) begin
    int h;
    hc = hc + 1;
    h = hc;
    #1;
    if (rst_n) begin
      checks++;
      if (exp_d.exists(h)) begin
        if (rvalid !== 1'b1 || rdata !== exp_d[h]) begin
          fails++;
          $display("FAIL R5/R8 edge %0d: rvalid=%b rdata=%h expected rvalid=1 rdata=%h",
                   h, rvalid, rdata, exp_d[h]);
        end
        exp_d.delete(h);
      end else if (rvalid !== 1'b0) begin
        fails++;
        $display("FAIL R6 edge %0d: rvalid=%b expected 0", h, rvalid);
      end
    end
  end

  // Entered one ns before a primary edge; returns one ns before the next slot's edge.
  task automatic run_slot(input vec_t v);
    logic [WW-1:0] snap;
    int h0;
    rd_en = v.rd; rd_addr = v.ra; wr_en = v.wr; wr_addr = v.wa;
    wdata = mk_beat(v.seed, 0); wbe = v.msk[1:0];
    @(posedge clk_k); #1;
    h0 = hc;
    if (v.rd) begin
      snap = ref_mem[v.ra];   // R7: read sees the state before this slot's write
      for (int i = 0; i < 4; i++) exp_d[h0 + 5 + i] = snap[i*DW +: DW];
    end
    rd_en = 1'b0; wr_en = 1'b0;
    wdata = mk_beat(v.seed, 1); wbe = v.msk[3:2];
    @(posedge clk_kb); #1;
    if (v.stray) begin       // R2: second-cycle commands must be ignored
      rd_en = 1'b1; rd_addr = 8'h10; wr_en = 1'b1; wr_addr = 8'h10;
    end
    wdata = mk_beat(v.seed, 2); wbe = v.msk[5:4];
    @(posedge clk_k); #1;
    rd_en = 1'b0; wr_en = 1'b0;
    wdata = mk_beat(v.seed, 3); wbe = v.msk[7:6];
    @(posedge clk_kb); #1;
    if (v.wr) begin
      for (int i = 0; i < 4; i++)
        for (int b = 0; b < NB; b++)
          if (v.msk[i*NB + b])
            ref_mem[v.wa][i*DW + b*BW +: BW] = mk_beat(v.seed, i)[b*BW +: BW];
    end
  endtask

  task automatic check_reset_state();
    checks++;
    if (rvalid !== 1'b0 || rdata !== '0) begin
      fails++;
      $display("FAIL R1: rvalid=%b rdata=%h expected rvalid=0 rdata=0", rvalid, rdata);
    end
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    for (int a = 0; a < DEPTH; a++) ref_mem[a] = '0;
    repeat (4) @(posedge clk_k);
    @(posedge clk_kb); #1;
    check_reset_state();                 // R1 during reset, complement phase
    @(posedge clk_k); #1;
    check_reset_state();                 // R1 during reset, primary phase
    @(posedge clk_kb); #1;
    rst_n = 1'b1;

    for (int n = 0; n < NV; n++) run_slot(VECS[n]);

    // Directed: reset again mid-run clears the array (R1).
    rst_n = 1'b0;
    repeat (3) @(posedge clk_k);
    @(posedge clk_kb); #1;
    check_reset_state();
    for (int a = 0; a < DEPTH; a++) ref_mem[a] = '0;
    rst_n = 1'b1;
    run_slot('{1'b1, 8'h10, 1'b0, 8'h00, 18'h00000, 8'h00, 1'b0});  // R1 cleared word
    run_slot('{1'b1, 8'hFF, 1'b1, 8'h05, 18'h0ABCD, 8'h3C, 1'b0});  // R1, R4 middle beats
    run_slot('{1'b1, 8'h05, 1'b0, 8'h00, 18'h00000, 8'h00, 1'b0});  // R8
    run_slot('{1'b0, 8'h00, 1'b0, 8'h00, 18'h00000, 8'h00, 1'b0});
    run_slot('{1'b0, 8'h00, 1'b0, 8'h00, 18'h00000, 8'h00, 1'b0});

    checks++;
    if (exp_d.size() != 0) begin
      fails++;
      $display("FAIL R5: %0d expected beats never observed, expected 0", exp_d.size());
    end
    finish_run();
  end
endmodule